// File: doc/BRIEF.md
# Bus-Idle Sleep and Restart Controller

This block decides the operating mode of a small measurement device from pin-level activity. When both wires of the two-wire serial bus (data and clock) are held low for a long window, it puts the device to sleep and asserts a halt enable that freezes the rest of the logic. The first rising edge on either wire wakes it at once. Waking does not reset any state, so the halted logic continues from where it stopped.

A strap input sets the role of an auxiliary pin. With the strap high, the pin carries an external 32 kHz time base and the block asserts a clock-select output. With the strap low, the pin is a restart request that is triggered on its rising edge. Hardware restart requests and a software restart strobe are merged into one single-cycle restart pulse. That pulse tells the estimator to start over as it does after power-up. No pulse is issued while the device sleeps.

The idle window is counted in ticks of a 32 kHz enable. The default of 72000 ticks is about 2.2 s, which falls inside the required 1.75 s to 2.5 s entry range. A high level on either bus line restarts the count.

Top module: `qs_sleep_ctrl`

## Requirements
- R1: After reset, `sleep_o`, `halt_o` and `qs_pulse_o` are 0.
- R2: With both bus lines low, `sleep_o` rises on the `IDLE_TICKS`-th tick and not earlier; after `IDLE_TICKS-1` ticks it is still 0.
- R3: A high level on either bus line clears the idle count, so a new full window of `IDLE_TICKS` ticks is needed before sleep.
- R4: While asleep, a rising edge on the data line or on the clock line clears `sleep_o` within 3 clock cycles (two synchronizer stages plus one register).
- R5: `halt_o` is 1 exactly while `sleep_o` is 1.
- R6: `clk_sel_ext_o` follows the strap input, after synchronization, with 1 meaning the external time base is selected.
- R7: With the strap low, each rising edge on the auxiliary pin produces exactly one `qs_pulse_o` cycle, however long the pin stays high.
- R8: With the strap high, edges on the auxiliary pin produce no `qs_pulse_o`.
- R9: A software restart strobe of any length produces exactly one `qs_pulse_o` cycle. Software and hardware requests that overlap produce one pulse.
- R10: No `qs_pulse_o` is produced while `sleep_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32 kHz tick enable, one clock wide |
| bus_data_in | input | 1 | Serial bus data line level (asynchronous) |
| bus_clk_in | input | 1 | Serial bus clock line level (asynchronous) |
| strap_ext_clk | input | 1 | Strap: 1 = aux pin is a time base, 0 = aux pin is a restart input |
| aux_in | input | 1 | Dual-purpose auxiliary pin (asynchronous) |
| sw_restart | input | 1 | Software restart strobe (synchronous) |
| sleep_o | output | 1 | Device is asleep |
| halt_o | output | 1 | Halt enable for the rest of the device |
| clk_sel_ext_o | output | 1 | External time base selected |
| qs_pulse_o | output | 1 | One-cycle restart pulse |

## Verification
The bench builds the block with `IDLE_TICKS` set to 16 and `SYNC_STAGES` left at 2. This makes the exact sleep threshold, the one-tick-short case and the counter clear partway through a window reachable in a few hundred cycles, with ticks issued one at a time. With two synchronizer stages, the wake latency and the edge-to-pulse latency are fixed, so they can be checked cycle by cycle. The strap is held in both positions, and restart requests are applied while awake and while asleep.

// File: rtl/qs_sleep_pkg.sv
package qs_sleep_pkg;

    // Synchronized view of one asynchronous pin.
    typedef struct packed {
        logic level;
        logic rise;
    } pin_view_t;

    // Operating mode of the block.
    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_SLEEP = 1'b1
    } op_mode_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync
    import qs_sleep_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output pin_view_t view
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign view.level = chain[STAGES-1];
    assign view.rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/idle_sleep_timer.sv
module idle_sleep_timer
    import qs_sleep_pkg::*;
#(
    parameter int unsigned IDLE_TICKS = 72000,
    localparam int unsigned CW = cnt_width(IDLE_TICKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  pin_view_t     dat,
    input  pin_view_t     scl,
    output logic [CW-1:0] idle_cnt,
    output op_mode_t      mode
);
    localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

    logic any_high;
    logic any_rise;

    assign any_high = dat.level | scl.level;
    assign any_rise = dat.rise | scl.rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (any_high) begin
            idle_cnt <= '0;
        end else if (tick && idle_cnt != LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RUN;
        end else if (any_rise) begin
            mode <= MODE_RUN;
        end else if (!any_high && tick && idle_cnt == LAST) begin
            mode <= MODE_SLEEP;
        end
    end
endmodule

// File: rtl/restart_pulse_gen.sv
module restart_pulse_gen (
    input  logic clk,
    input  logic rst,
    input  logic hw_req,
    input  logic sw_req,
    input  logic asleep,
    output logic pulse
);
    logic req;
    logic req_q;

    assign req = hw_req | sw_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            pulse <= 1'b0;
        end else begin
            req_q <= req;
            pulse <= req & ~req_q & ~asleep;
        end
    end
endmodule

// File: rtl/qs_sleep_ctrl.sv
module qs_sleep_ctrl
    import qs_sleep_pkg::*;
#(
    parameter int unsigned IDLE_TICKS  = 72000,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CW = cnt_width(IDLE_TICKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bus_data_in,
    input  logic bus_clk_in,
    input  logic strap_ext_clk,
    input  logic aux_in,
    input  logic sw_restart,
    output logic sleep_o,
    output logic halt_o,
    output logic clk_sel_ext_o,
    output logic qs_pulse_o
);
    localparam int unsigned NPINS = 4;

    logic [NPINS-1:0] raw;
    pin_view_t        views [NPINS];
    pin_view_t        dat_v, scl_v, strap_v, aux_v;
    logic [CW-1:0]    idle_cnt;
    op_mode_t         mode;

    assign raw = {aux_in, strap_ext_clk, bus_clk_in, bus_data_in};

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_sync
            pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .pin  (raw[i]),
                .view (views[i])
            );
        end
    endgenerate

    assign dat_v   = views[0];
    assign scl_v   = views[1];
    assign strap_v = views[2];
    assign aux_v   = views[3];

    idle_sleep_timer #(.IDLE_TICKS(IDLE_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .dat      (dat_v),
        .scl      (scl_v),
        .idle_cnt (idle_cnt),
        .mode     (mode)
    );

    restart_pulse_gen u_pulse (
        .clk    (clk),
        .rst    (rst),
        .hw_req (aux_v.rise & ~strap_v.level),
        .sw_req (sw_restart),
        .asleep (mode == MODE_SLEEP),
        .pulse  (qs_pulse_o)
    );

    assign sleep_o       = (mode == MODE_SLEEP);
    assign halt_o        = sleep_o;
    assign clk_sel_ext_o = strap_v.level;
endmodule

// File: rtl/qs_sleep_ctrl_chk.sv
module qs_sleep_ctrl_chk #(
    parameter int unsigned IDLE_TICKS = 72000,
    parameter int unsigned CW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          line_high,
    input logic          line_rise,
    input logic [CW-1:0] idle_cnt,
    input logic          sleep_o,
    input logic          halt_o,
    input logic          qs_pulse_o
);
    assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (rst)
        line_high |=> idle_cnt == '0);

    assert_sleep_at_limit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> ($past(idle_cnt) == CW'(IDLE_TICKS - 1) && $past(tick)));

    assert_wake_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && line_rise) |=> !sleep_o);

    assert_no_pulse_asleep_R10: assert property (@(posedge clk) disable iff (rst)
        sleep_o |=> !qs_pulse_o);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        qs_pulse_o |=> !qs_pulse_o);

    assert_halt_tracks_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> halt_o);
endmodule

bind qs_sleep_ctrl qs_sleep_ctrl_chk #(.IDLE_TICKS(IDLE_TICKS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .line_high  (dat_v.level | scl_v.level),
    .line_rise  (dat_v.rise | scl_v.rise),
    .idle_cnt   (idle_cnt),
    .sleep_o    (sleep_o),
    .halt_o     (halt_o),
    .qs_pulse_o (qs_pulse_o)
);

// File: tb/sim_qs_sleep_ctrl.sv
module sim_qs_sleep_ctrl;
    localparam int CLK_P = 10;
    localparam int IDLE  = 16;

    logic clk = 1'b0;
    logic rst, tick, sda, scl, strap, aux, swr;
    logic sleep_o, halt_o, clk_sel_ext_o, qs_pulse_o;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cycles = 0;

    always #(CLK_P/2) clk = ~clk;

    qs_sleep_ctrl #(.IDLE_TICKS(IDLE), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .bus_data_in(sda), .bus_clk_in(scl),
        .strap_ext_clk(strap), .aux_in(aux), .sw_restart(swr),
        .sleep_o(sleep_o), .halt_o(halt_o),
        .clk_sel_ext_o(clk_sel_ext_o), .qs_pulse_o(qs_pulse_o)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (qs_pulse_o) pulses <= pulses + 1;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles, expected at most 100000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic go_sleep();
        @(negedge clk); sda = 1'b0; scl = 1'b0; tick = 1'b0;
        wait_n(4);
        give_ticks(IDLE);
        wait_n(2);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick = 0; sda = 1; scl = 1; strap = 0; aux = 0; swr = 0;
        wait_n(4);
        rst = 1'b0;
        wait_n(4);
        chk("R1 sleep after reset", sleep_o, 0);
        chk("R1 halt after reset", halt_o, 0);
        chk("R1 pulse after reset", pulses, 0);
    endtask

    task automatic t_sleep_entry();
        @(negedge clk); sda = 0; scl = 0;
        wait_n(4);
        give_ticks(IDLE - 1);
        wait_n(2);
        chk("R2 awake one tick short", sleep_o, 0);
        give_ticks(1);
        wait_n(1);
        chk("R2 asleep at limit", sleep_o, 1);
        chk("R5 halt while asleep", halt_o, 1);
    endtask

    task automatic t_wake(input bit use_data);
        @(negedge clk);
        if (use_data) sda = 1'b1; else scl = 1'b1;
        wait_n(2);
        chk("R4 still asleep before sync", sleep_o, 1);
        wait_n(1);
        chk(use_data ? "R4 wake on data edge" : "R4 wake on clock edge", sleep_o, 0);
        chk("R5 halt released", halt_o, 0);
    endtask

    task automatic t_counter_clear();
        @(negedge clk); sda = 0; scl = 0;
        wait_n(4);
        give_ticks(IDLE - 2);
        @(negedge clk); scl = 1'b1;
        wait_n(4);
        @(negedge clk); scl = 1'b0;
        wait_n(4);
        give_ticks(IDLE - 1);
        wait_n(2);
        chk("R3 count cleared by high level", sleep_o, 0);
        give_ticks(1);
        wait_n(1);
        chk("R3 sleeps after a fresh window", sleep_o, 1);
        @(negedge clk); sda = 1; scl = 1;
        wait_n(4);
        chk("R4 awake again", sleep_o, 0);
    endtask

    task automatic t_hw_qs();
        int p0;
        strap = 0;
        wait_n(4);
        chk("R6 clock select low", clk_sel_ext_o, 0);
        p0 = pulses;
        @(negedge clk); aux = 1'b1;
        wait_n(12);
        chk("R7 one pulse per aux edge", pulses - p0, 1);
        @(negedge clk); aux = 1'b0;
        wait_n(3);
        @(negedge clk); aux = 1'b1;
        wait_n(6);
        @(negedge clk); aux = 1'b0;
        wait_n(4);
        chk("R7 second aux edge", pulses - p0, 2);
    endtask

    task automatic t_strap_ext();
        int p0;
        @(negedge clk); strap = 1'b1;
        wait_n(4);
        chk("R6 clock select high", clk_sel_ext_o, 1);
        p0 = pulses;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); aux = 1'b1;
            @(negedge clk); aux = 1'b0;
        end
        wait_n(5);
        chk("R8 no pulse in clock mode", pulses - p0, 0);
        @(negedge clk); strap = 1'b0;
        wait_n(4);
    endtask

    task automatic t_sw_qs();
        int p0;
        p0 = pulses;
        @(negedge clk); swr = 1'b1;
        wait_n(5);
        @(negedge clk); swr = 1'b0;
        wait_n(3);
        chk("R9 long strobe one pulse", pulses - p0, 1);
        p0 = pulses;
        @(negedge clk); swr = 1'b1;
        @(negedge clk); swr = 1'b0;
        wait_n(3);
        chk("R9 short strobe one pulse", pulses - p0, 1);
    endtask

    task automatic t_merged();
        int p0;
        p0 = pulses;
        @(negedge clk); aux = 1'b1; swr = 1'b1;
        wait_n(6);
        @(negedge clk); swr = 1'b0;
        wait_n(6);
        @(negedge clk); aux = 1'b0;
        wait_n(4);
        chk("R9 merged requests one pulse", pulses - p0, 1);
    endtask

    task automatic t_qs_asleep();
        int p0;
        go_sleep();
        chk("R10 precondition asleep", sleep_o, 1);
        p0 = pulses;
        @(negedge clk); swr = 1'b1;
        @(negedge clk); swr = 1'b0;
        @(negedge clk); aux = 1'b1;
        wait_n(6);
        @(negedge clk); aux = 1'b0;
        wait_n(4);
        chk("R10 no pulse while asleep", pulses - p0, 0);
        chk("R10 still asleep", sleep_o, 1);
        @(negedge clk); sda = 1; scl = 1;
        wait_n(4);
    endtask

    initial begin
        t_reset();
        t_sleep_entry();
        t_wake(1'b1);
        go_sleep();
        t_wake(1'b0);
        @(negedge clk); sda = 1; scl = 1;
        wait_n(3);
        t_counter_clear();
        t_hw_qs();
        t_strap_ext();
        t_sw_qs();
        t_merged();
        t_qs_asleep();
        summary();
    end
endmodule